// File: doc/BRIEF.md
# Range Maintenance Request Splitter

This block turns one cache maintenance request (invalidate, clean or flush over a byte range with an exclusive end) into a stream of bounded commands for a downstream range walker. Each range command carries an inclusive first-line address and an inclusive last-line address. No range command covers more than a fixed number of bytes or crosses a page. For an invalidate, any partial line at either edge is not dropped. It is instead cleaned and invalidated by a single-line command, so that dirty bytes outside the range survive.

A write-through override input tells the block that the cache can never hold dirty data. In that case clean work is skipped. A done pulse marks the end of each request, including requests that produce no commands. A new request is accepted only when the block is idle.

Top module: `maint_range_splitter`

## Requirements
- R1: Every range command carries an inclusive end (`cmd_hi`) equal to its chunk's exclusive end minus one line (32 bytes by default). `cmd_lo` is the chunk start.
- R2: Each chunk's exclusive end is the smallest of three values: the aligned request end, the chunk start plus 1024 bytes, and the next page boundary above the chunk start (page size 4096 by default).
- R3: For an invalidate (op code 0) whose start is not line aligned, a single-line command (type 0) is issued for the line holding the start. The walk then begins at the next line boundary.
- R4: For an invalidate, if the adjusted start is still below the end and the end is not line aligned, a single-line command (type 0) is issued for the end's line after any start-edge command. The end is then rounded down to a line boundary. If the adjusted start is not below the end, no end-edge command is issued.
- R5: For clean (op code 1) and flush (op code 2), the start is rounded down and the end is rounded up to a line boundary before splitting. Every command address is line aligned.
- R6: For a flush without override, each chunk produces a clean-range command (type 1) followed by an invalidate-range command (type 2) with identical bounds.
- R7: When `wt_override` is high at request acceptance, a clean request produces no commands and a flush produces only invalidate-range commands (type 2). No clean-range command is issued for that request.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of the request's last command. For a request with no commands, it is high in the cycle after the request handshake.
- R9: `req_ready` is low from the request handshake until after the `done` cycle. A request held valid meanwhile is not taken and does not alter the commands of the current request.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid and its type and addresses stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_override | input | 1 | Write-through override, sampled at request handshake |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | ADDR_W | First byte address |
| req_end | input | ADDR_W | Exclusive end byte address |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by walker |
| cmd_type | output | 2 | 0 single-line clean+invalidate, 1 clean range, 2 invalidate range |
| cmd_lo | output | ADDR_W | Inclusive first line address |
| cmd_hi | output | ADDR_W | Inclusive last line address |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The hardest situation to reach is a flush whose clean half of a chunk is held off by the walker. The bench must show that the paired invalidate reuses the same bounds and that the walk advances only after the second half is taken. It gets there by driving a flush while dropping `cmd_ready` on two of every three cycles, and it checks at each stalled cycle that the offered command is unchanged. The second hard case is an invalidate whose start and end share one line. It is reached with a request a few bytes wide inside a single line, which must yield one edge command and no end-edge command.

// File: rtl/maint_pkg.sv
package maint_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_LINE_CI     = 2'd0,
        CMD_CLEAN_RANGE = 2'd1,
        CMD_INV_RANGE   = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_BODY,
        ST_DONE
    } state_e;

endpackage

// File: rtl/maint_edge_align.sv
module maint_edge_align
    import maint_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              head_f,
    output logic [ADDR_W-1:0] head_line,
    output logic              tail_f,
    output logic [ADDR_W-1:0] tail_line,
    output logic [ADDR_W-1:0] body_lo,
    output logic [ADDR_W-1:0] body_stop
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] start_dn;
    logic [ADDR_W-1:0] start_up;
    logic [ADDR_W-1:0] end_dn;
    logic [ADDR_W-1:0] end_up;
    logic              start_part;
    logic              end_part;

    always_comb begin
        start_dn   = start_addr & ~LINE_MASK;
        start_up   = (start_addr | LINE_MASK) + ADDR_W'(1);
        end_dn     = end_addr & ~LINE_MASK;
        end_up     = (end_addr + LINE_MASK) & ~LINE_MASK;
        start_part = (start_addr & LINE_MASK) != '0;
        end_part   = (end_addr & LINE_MASK) != '0;

        head_line  = start_dn;
        tail_line  = end_dn;
        head_f     = 1'b0;
        tail_f     = 1'b0;
        body_lo    = start_dn;
        body_stop  = end_up;

        if (op == OP_INV) begin
            head_f    = start_part;
            body_lo   = start_part ? start_up : start_addr;
            tail_f    = (body_lo < end_addr) && end_part;
            body_stop = tail_f ? end_dn : end_addr;
        end
    end
endmodule

// File: rtl/maint_chunk_limit.sv
module maint_chunk_limit #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] stop,
    output logic [ADDR_W-1:0] chunk_end,
    output logic              chunk_last
);
    localparam int XW = ADDR_W + 1;
    localparam logic [XW-1:0] PAGE_MASK = XW'(PAGE_BYTES - 1);
    localparam logic [XW-1:0] CHUNK_X   = XW'(CHUNK_BYTES);

    logic [XW-1:0] cur_x;
    logic [XW-1:0] stop_x;
    logic [XW-1:0] cap_x;
    logic [XW-1:0] page_x;
    logic [XW-1:0] lim_x;

    always_comb begin
        cur_x  = {1'b0, cur};
        stop_x = {1'b0, stop};
        cap_x  = cur_x + CHUNK_X;
        page_x = (cur_x | PAGE_MASK) + XW'(1);
        lim_x  = stop_x;
        if (cap_x < lim_x)  lim_x = cap_x;
        if (page_x < lim_x) lim_x = page_x;
        chunk_end  = lim_x[ADDR_W-1:0];
        chunk_last = lim_x >= stop_x;
    end
endmodule

// File: rtl/maint_cmd_seq.sv
module maint_cmd_seq
    import maint_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_override,
    input  logic              req_valid,
    output logic              req_ready,
    input  op_e               req_op,
    input  logic              head_f,
    input  logic [ADDR_W-1:0] head_line,
    input  logic              tail_f,
    input  logic [ADDR_W-1:0] tail_line,
    input  logic [ADDR_W-1:0] body_lo,
    input  logic [ADDR_W-1:0] body_stop,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] stop,
    input  logic [ADDR_W-1:0] chunk_end,
    input  logic              chunk_last,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output cmd_e              cmd_type,
    output logic [ADDR_W-1:0] cmd_lo,
    output logic [ADDR_W-1:0] cmd_hi,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LINE_SZ   = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);
    localparam int               PAGE_SH   = $clog2(PAGE_BYTES);

    state_e            state;
    op_e               op_r;
    logic              wt_r;
    logic              tail_r;
    logic              body_r;
    logic              clean_ph;
    logic [ADDR_W-1:0] hline_r;
    logic [ADDR_W-1:0] tline_r;
    logic [ADDR_W-1:0] cur_r;
    logic [ADDR_W-1:0] stop_r;

    logic req_fire;
    logic cmd_fire;
    logic body_go;

    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign body_go   = (body_lo < body_stop) && !(req_op == OP_CLEAN && wt_override);
    assign cur       = cur_r;
    assign stop      = stop_r;
    assign done      = (state == ST_DONE);

    always_comb begin
        cmd_valid = 1'b0;
        cmd_type  = CMD_LINE_CI;
        cmd_lo    = cur_r;
        cmd_hi    = chunk_end - LINE_SZ;
        unique case (state)
            ST_HEAD: begin
                cmd_valid = 1'b1;
                cmd_lo    = hline_r;
                cmd_hi    = hline_r;
            end
            ST_TAIL: begin
                cmd_valid = 1'b1;
                cmd_lo    = tline_r;
                cmd_hi    = tline_r;
            end
            ST_BODY: begin
                cmd_valid = 1'b1;
                if (op_r == OP_CLEAN || (op_r == OP_FLUSH && clean_ph))
                    cmd_type = CMD_CLEAN_RANGE;
                else
                    cmd_type = CMD_INV_RANGE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_r     <= OP_INV;
            wt_r     <= 1'b0;
            tail_r   <= 1'b0;
            body_r   <= 1'b0;
            clean_ph <= 1'b0;
            hline_r  <= '0;
            tline_r  <= '0;
            cur_r    <= '0;
            stop_r   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_fire) begin
                    op_r     <= req_op;
                    wt_r     <= wt_override;
                    tail_r   <= tail_f;
                    body_r   <= body_go;
                    clean_ph <= (req_op == OP_FLUSH) && !wt_override;
                    hline_r  <= head_line;
                    tline_r  <= tail_line;
                    cur_r    <= body_lo;
                    stop_r   <= body_stop;
                    if (head_f)       state <= ST_HEAD;
                    else if (tail_f)  state <= ST_TAIL;
                    else if (body_go) state <= ST_BODY;
                    else              state <= ST_DONE;
                end
                ST_HEAD: if (cmd_fire) begin
                    if (tail_r)      state <= ST_TAIL;
                    else if (body_r) state <= ST_BODY;
                    else             state <= ST_DONE;
                end
                ST_TAIL: if (cmd_fire) begin
                    state <= body_r ? ST_BODY : ST_DONE;
                end
                ST_BODY: if (cmd_fire) begin
                    if (op_r == OP_FLUSH && clean_ph) begin
                        clean_ph <= 1'b0;
                    end else begin
                        cur_r    <= chunk_end;
                        clean_ph <= (op_r == OP_FLUSH) && !wt_r;
                        if (chunk_last) state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: an offered command is held until taken
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_type)
                                    && $stable(cmd_lo) && $stable(cmd_hi));

    // R2: a range command never spans more than one chunk or one page
    p_chunk_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type != CMD_LINE_CI |->
            (cmd_hi - cmd_lo) < ADDR_W'(CHUNK_BYTES)
            && ((cmd_lo ^ cmd_hi) >> PAGE_SH) == '0);

    // R5: command addresses sit on line boundaries
    p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((cmd_lo | cmd_hi) & LINE_MASK) == '0);

    // R6: a flush clean half is followed by an invalidate on the same bounds
    p_flush_pair_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && op_r == OP_FLUSH && cmd_type == CMD_CLEAN_RANGE |=>
            cmd_valid && cmd_type == CMD_INV_RANGE
            && $stable(cmd_lo) && $stable(cmd_hi));

    // R7: override suppresses every clean-range command
    p_no_clean_wt_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && wt_r |-> cmd_type != CMD_CLEAN_RANGE);

    // R8: done lasts a single cycle and never overlaps a command
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid ##1 !done);

    // R9: no request is taken while a request is in progress
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid || done |-> !req_ready);
endmodule

// File: rtl/maint_range_splitter.sv
module maint_range_splitter
    import maint_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_override,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_type,
    output logic [ADDR_W-1:0] cmd_lo,
    output logic [ADDR_W-1:0] cmd_hi,
    output logic              done
);
    op_e               op_in;
    cmd_e              type_out;
    logic              head_f;
    logic              tail_f;
    logic [ADDR_W-1:0] head_line;
    logic [ADDR_W-1:0] tail_line;
    logic [ADDR_W-1:0] body_lo;
    logic [ADDR_W-1:0] body_stop;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] stop;
    logic [ADDR_W-1:0] chunk_end;
    logic              chunk_last;

    assign op_in    = op_e'(req_op);
    assign cmd_type = type_out;

    maint_edge_align #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .op         (op_in),
        .start_addr (req_start),
        .end_addr   (req_end),
        .head_f     (head_f),
        .head_line  (head_line),
        .tail_f     (tail_f),
        .tail_line  (tail_line),
        .body_lo    (body_lo),
        .body_stop  (body_stop)
    );

    maint_chunk_limit #(
        .ADDR_W      (ADDR_W),
        .CHUNK_BYTES (CHUNK_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_limit (
        .cur        (cur),
        .stop       (stop),
        .chunk_end  (chunk_end),
        .chunk_last (chunk_last)
    );

    maint_cmd_seq #(
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wt_override (wt_override),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (op_in),
        .head_f      (head_f),
        .head_line   (head_line),
        .tail_f      (tail_f),
        .tail_line   (tail_line),
        .body_lo     (body_lo),
        .body_stop   (body_stop),
        .cur         (cur),
        .stop        (stop),
        .chunk_end   (chunk_end),
        .chunk_last  (chunk_last),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_type    (type_out),
        .cmd_lo      (cmd_lo),
        .cmd_hi      (cmd_hi),
        .done        (done)
    );
endmodule

// File: tb/maint_range_splitter_bench.sv
module maint_range_splitter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wt_override;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [31:0] req_start;
    logic [31:0] req_end;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_type;
    logic [31:0] cmd_lo;
    logic [31:0] cmd_hi;
    logic        done;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  exp_t [64];
    logic [31:0] exp_lo[64];
    logic [31:0] exp_hi[64];
    int          n_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    maint_range_splitter u_maint_range_splitter (
        .clk(clk), .rst(rst), .wt_override(wt_override),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_start(req_start), .req_end(req_end),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] t, input logic [31:0] lo, input logic [31:0] hi);
        exp_t[n_exp]  = t;
        exp_lo[n_exp] = lo;
        exp_hi[n_exp] = hi;
        n_exp++;
    endtask

    // Expected command list, built from R1-style rules written independently
    task automatic build_exp(input int op, input logic [31:0] s_in,
                             input logic [31:0] e_in, input bit wt);
        logic [31:0] s = s_in;
        logic [31:0] e = e_in;
        logic [31:0] ce;
        n_exp = 0;
        if (op == 0) begin
            if (s[4:0] != 0) begin push(2'd0, s & ~32'd31, s & ~32'd31); s = (s | 32'd31) + 1; end
            if (s < e && e[4:0] != 0) begin push(2'd0, e & ~32'd31, e & ~32'd31); e = e & ~32'd31; end
        end else begin
            s = s & ~32'd31;
            e = (e + 32'd31) & ~32'd31;
        end
        while (s < e) begin
            ce = e;
            if (ce > s + 32'd1024) ce = s + 32'd1024;
            if (ce > (s | 32'd4095) + 1) ce = (s | 32'd4095) + 1;
            if (op != 0 && !wt) push(2'd1, s, ce - 32'd32);
            if (op != 1) push(2'd2, s, ce - 32'd32);
            s = ce;
        end
    endtask

    // Drives one request and checks every command and the done pulse.
    // busy_poke holds a second request valid while busy (R9).
    task automatic run_req(input string req, input int op, input logic [31:0] s,
                           input logic [31:0] e, input bit wt, input bit stall,
                           input bit busy_poke);
        int  got = 0;
        int  cyc = 0;
        bit  acc_prev;
        bit  held_prev = 0;
        logic [1:0]  pt = '0;
        logic [31:0] plo = '0, phi = '0;
        build_exp(op, s, e, wt);
        @(negedge clk);
        check(req_ready == 1'b1, "R9", {req, " idle ready"}, {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_op = 2'(op); req_start = s; req_end = e; wt_override = wt;
        @(negedge clk);
        acc_prev = 1;
        if (busy_poke) begin
            req_op = 2'd1; req_start = 32'h0000_8000; req_end = 32'h0000_8400;
        end else req_valid = 1'b0;
        forever begin
            if (done) begin
                check(acc_prev && got == n_exp, "R8", {req, " done timing"}, got, n_exp);
                cmd_ready = 1'b0;
                req_valid = 1'b0;
                @(negedge clk);
                check(done == 1'b0, "R8", {req, " done width"}, {31'd0, done}, 32'd0);
                break;
            end
            if (busy_poke)
                check(req_ready == 1'b0, "R9", {req, " busy ready"}, {31'd0, req_ready}, 32'd0);
            acc_prev = 0;
            if (held_prev)
                check(cmd_valid && cmd_type == pt && cmd_lo == plo && cmd_hi == phi,
                      "R10", {req, " stalled command"}, cmd_lo, plo);
            held_prev = 0;
            if (cmd_valid) begin
                cmd_ready = stall ? (cyc % 3 == 2) : 1'b1;
                if (cmd_ready) begin
                    if (got < n_exp)
                        check(cmd_type == exp_t[got] && cmd_lo == exp_lo[got] && cmd_hi == exp_hi[got],
                              req, {req, " command"},
                              {cmd_type, cmd_lo[29:0]}, {exp_t[got], exp_lo[got][29:0]});
                    else
                        check(1'b0, req, {req, " extra command"}, cmd_lo, 32'd0);
                    if (got < n_exp)
                        check(cmd_hi == exp_hi[got], req, {req, " inclusive end"}, cmd_hi, exp_hi[got]);
                    got++;
                    acc_prev = 1;
                end else begin
                    held_prev = 1; pt = cmd_type; plo = cmd_lo; phi = cmd_hi;
                end
            end else cmd_ready = 1'b0;
            cyc++;
            if (cyc > 2000) begin
                check(1'b0, req, {req, " no done"}, got, n_exp);
                break;
            end
            @(negedge clk);
        end
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R9",
              "reset state", {29'd0, req_ready, cmd_valid, done}, 32'd4);
    endtask

    // R1: aligned invalidate inside one chunk
    task automatic t_inv_aligned;
        run_req("R1", 0, 32'h0000_1000, 32'h0000_1100, 0, 0, 0);
    endtask

    // R3, R4: both edges partial
    task automatic t_inv_edges;
        run_req("R3", 0, 32'h0000_1004, 32'h0000_1108, 0, 0, 0);
        run_req("R4", 0, 32'h0000_5020, 32'h0000_5047, 0, 1, 0);
    endtask

    // R4: start and end in one line, no end-edge command
    task automatic t_inv_one_line;
        run_req("R4", 0, 32'h0000_2004, 32'h0000_2010, 0, 0, 0);
    endtask

    // R2, R5: clean crossing pages and the chunk cap
    task automatic t_clean_split;
        run_req("R2", 1, 32'h0000_0F10, 32'h0000_1901, 0, 0, 0);
        run_req("R5", 1, 32'h0000_3FFF, 32'h0000_4001, 0, 0, 0);
    endtask

    // R6, R10: flush pairs under a stalling walker
    task automatic t_flush_stall;
        run_req("R6", 2, 32'h0000_3010, 32'h0000_3450, 0, 1, 0);
    endtask

    // R7: override on clean and flush
    task automatic t_wt;
        run_req("R7", 1, 32'h0000_6000, 32'h0000_6800, 1, 0, 0);
        run_req("R7", 2, 32'h0000_6010, 32'h0000_6500, 1, 0, 0);
    endtask

    // R8: zero-command invalidate (empty range)
    task automatic t_empty;
        run_req("R8", 0, 32'h0000_7000, 32'h0000_7000, 0, 0, 0);
    endtask

    // R9: a second request held valid while busy
    task automatic t_busy;
        run_req("R9", 2, 32'h0000_9000, 32'h0000_9100, 0, 1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wt_override = 1'b0; req_valid = 1'b0; req_op = '0;
        req_start = '0; req_end = '0; cmd_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_inv_aligned();
        t_inv_edges();
        t_inv_one_line();
        t_clean_split();
        t_flush_stall();
        t_wt();
        t_empty();
        t_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule